// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is an on-chip synchronous static memory whose address and control are pipelined two clock steps ahead of the data. Each access is issued on a rising clock edge, and its data slot comes two *enabled* edges later. For a write, the write data is sampled at that edge. For a read, the read data is registered onto the output bus at that edge. Because reads and writes share the same fixed latency, they can follow each other on every cycle and the bus never needs an idle turnaround cycle. The default array is 256 words of 18 bits, split into two 9-bit byte lanes. Each lane has its own active-low write enable, issued together with the address.

A short burst mode lets one loaded address be followed by advance cycles. On each advance, a 2-bit counter in the low address bits steps through a four-word group and wraps linearly. The burst keeps the direction chosen on the load cycle. A front-end state machine holds that direction in one of three states:

- `ST_DESEL` (no access)
- `ST_READ`
- `ST_WRITE`

On every load cycle the machine moves to `ST_READ` or `ST_WRITE` when the chip is selected, and to `ST_DESEL` when it is not. On every advance cycle it stays in its current state. Reset enters `ST_DESEL`.

A clock-hold input freezes every register, which stretches the previous cycle. A sleep input does the same, ignores all other inputs and removes output drive. An asynchronous active-low output enable gates only the output drive.

Top module: `zt_sram`

## Requirements
- R1: A read loaded at enabled edge E (ld_n=0, selected, rd_wr_n=1) drives dq_drive=1 with dq_out equal to the addressed word after the second enabled edge following E, provided oe_n=0 and sleep=0.
- R2: A write loaded at enabled edge E (rd_wr_n=0) stores wdata as presented at the second enabled edge after E. Bit 0 of bwe_n gates lane bits [8:0] and bit 1 gates bits [17:9]; a lane is written only when its bit is 0 at edge E.
- R3: Reads and writes may be issued on consecutive enabled edges in any mix with no idle cycle, and every read returns the latest data written before its data slot.
- R4: An advance edge (ld_n=1) issues the address whose upper bits equal the previous issued address and whose low 2 bits are the previous low bits plus one modulo 4. It issues the same direction as the last load, and rd_wr_n is ignored.
- R5: The chip is selected on a load edge only when sel_a_n=0, sel_b_n=0 and sel_c=1. A deselected load produces no drive in its data slot, and the select inputs have no effect on advance edges.
- R6: While clk_hold=1, no register changes: dq_out, dq_drive and the array contents stay as they were.
- R7: oe_n=1 forces dq_drive=0 without waiting for a clock edge and does not disturb the pipeline.
- R8: While sleep=1, dq_drive=0, all other inputs are ignored, and the array contents are retained.
- R9: After reset, dq_drive=0 and the front end is deselected, so advance edges issue no access until a selected load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_hold | input | 1 | 1 = ignore the clock and hold all state |
| sleep | input | 1 | 1 = low-power hold, inputs ignored, no drive |
| ld_n | input | 1 | 0 = load a new address, 1 = advance the burst |
| rd_wr_n | input | 1 | 1 = read, 0 = write (load edges only) |
| sel_a_n | input | 1 | Active-low chip select |
| sel_b_n | input | 1 | Active-low chip select |
| sel_c | input | 1 | Active-high chip select |
| bwe_n | input | LANES (2) | Active-low per-lane write enables, given with the address |
| addr | input | AW (8) | Word address |
| wdata | input | DATA_W (18) | Write data for the access issued two enabled edges earlier |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dq_out | output | DATA_W (18) | Read data bus |
| dq_drive | output | 1 | 1 when dq_out is driven, 0 for high impedance |

## Verification
The array is first filled with write bursts that wrap through every four-word group. A reference model delayed by the same two enabled edges then predicts every output cycle. Directed patterns do the following:

- Alternating read and write at one address, which separates a correct data slot from one that is off by an edge.
- A half-lane write, which exposes a swapped or ignored lane enable.
- Deselected loads followed by advances with the selects switched on, which shows whether selects leak into advance cycles.
- Hold and sleep stretches placed inside a burst, which show whether a frozen edge still moves the pipeline.

A long random mix of loads, advances, stalls, sleeps and output-enable changes then checks that the interleaving holds under arbitrary order.

// File: rtl/zt_pkg.sv
package zt_pkg;
    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } op_e;

    typedef enum logic [1:0] {
        ST_DESEL = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } dir_st_e;
endpackage

// File: rtl/zt_front.sv
// Front end: direction state machine plus the burst address counter.
module zt_front
    import zt_pkg::*;
#(
    parameter int AW      = 8,
    parameter int BURST_W = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          ld_n,
    input  logic          rd_wr_n,
    input  logic          sel_a_n,
    input  logic          sel_b_n,
    input  logic          sel_c,
    input  logic [AW-1:0] addr,
    output op_e           iss_op,
    output logic [AW-1:0] iss_addr
);
    dir_st_e       st_q, st_d;
    logic [AW-1:0] cur_q, cur_d;
    logic          chosen;

    assign chosen = !sel_a_n && !sel_b_n && sel_c;

    // next state: selects and direction only matter on a load edge
    always_comb begin
        st_d  = st_q;
        cur_d = {cur_q[AW-1:BURST_W], cur_q[BURST_W-1:0] + BURST_W'(1)};
        if (!ld_n) begin
            cur_d = addr;
            if (!chosen)      st_d = ST_DESEL;
            else if (rd_wr_n) st_d = ST_READ;
            else              st_d = ST_WRITE;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_DESEL;
            cur_q <= '0;
        end else if (en) begin
            st_q  <= st_d;
            cur_q <= cur_d;
        end
    end

    // outputs: the access issued at this edge
    always_comb begin
        iss_addr = cur_d;
        unique case (st_d)
            ST_DESEL: iss_op = OP_NONE;
            ST_READ:  iss_op = OP_RD;
            ST_WRITE: iss_op = OP_WR;
            default:  iss_op = OP_NONE;
        endcase
    end
endmodule

// File: rtl/zt_pipe.sv
// Delay line carrying op, address and lane enables to the data slot.
module zt_pipe
    import zt_pkg::*;
#(
    parameter int AW     = 8,
    parameter int LANES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  op_e              in_op,
    input  logic [AW-1:0]    in_addr,
    input  logic [LANES-1:0] in_bwe_n,
    output op_e              s1_op,
    output logic [AW-1:0]    s1_addr,
    output op_e              out_op,
    output logic [AW-1:0]    out_addr,
    output logic [LANES-1:0] out_bwe_n
);
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        op_e              op_r, op_src;
        logic [AW-1:0]    a_r, a_src;
        logic [LANES-1:0] b_r, b_src;

        if (g == 0) begin : g_head
            assign op_src = in_op;
            assign a_src  = in_addr;
            assign b_src  = in_bwe_n;
        end else begin : g_body
            assign op_src = g_stage[g-1].op_r;
            assign a_src  = g_stage[g-1].a_r;
            assign b_src  = g_stage[g-1].b_r;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                op_r <= OP_NONE;
                a_r  <= '0;
                b_r  <= '1;
            end else if (en) begin
                op_r <= op_src;
                a_r  <= a_src;
                b_r  <= b_src;
            end
        end
    end

    assign s1_op     = g_stage[0].op_r;
    assign s1_addr   = g_stage[0].a_r;
    assign out_op    = g_stage[STAGES-1].op_r;
    assign out_addr  = g_stage[STAGES-1].a_r;
    assign out_bwe_n = g_stage[STAGES-1].b_r;
endmodule

// File: rtl/zt_array.sv
// Lane-split storage with a registered read port.
module zt_array
    import zt_pkg::*;
#(
    parameter int AW     = 8,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  op_e                     op,
    input  logic [AW-1:0]           addr,
    input  logic [LANES-1:0]        bwe_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rd_data,
    output logic                    rd_live
);
    localparam int DEPTH = 1 << AW;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] mem_r [DEPTH];
        logic [LANE_W-1:0] q_r;

        always_ff @(posedge clk) begin
            if (en && op == OP_WR && !bwe_n[l])
                mem_r[addr] <= wdata[l*LANE_W +: LANE_W];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  q_r <= '0;
            else if (en && op == OP_RD)  q_r <= mem_r[addr];
        end

        assign rd_data[l*LANE_W +: LANE_W] = q_r;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  rd_live <= 1'b0;
        else if (en) rd_live <= (op == OP_RD);
    end
endmodule

// File: rtl/zt_sram.sv
module zt_sram
    import zt_pkg::*;
#(
    parameter int AW      = 8,
    parameter int LANE_W  = 9,
    parameter int LANES   = 2,
    parameter int BURST_W = 2,
    parameter int STAGES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_hold,
    input  logic                    sleep,
    input  logic                    ld_n,
    input  logic                    rd_wr_n,
    input  logic                    sel_a_n,
    input  logic                    sel_b_n,
    input  logic                    sel_c,
    input  logic [LANES-1:0]        bwe_n,
    input  logic [AW-1:0]           addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    oe_n,
    output logic [LANES*LANE_W-1:0] dq_out,
    output logic                    dq_drive
);
    localparam int DATA_W = LANES * LANE_W;

    logic             en;
    op_e              iss_op, s1_op, s2_op;
    logic [AW-1:0]    iss_addr, s1_addr, s2_addr;
    logic [LANES-1:0] s2_bwe_n;
    logic             rd_live;

    assign en = !clk_hold && !sleep;

    zt_front #(.AW(AW), .BURST_W(BURST_W)) u_front (
        .clk(clk), .rst_n(rst_n), .en(en),
        .ld_n(ld_n), .rd_wr_n(rd_wr_n),
        .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .sel_c(sel_c),
        .addr(addr), .iss_op(iss_op), .iss_addr(iss_addr)
    );

    zt_pipe #(.AW(AW), .LANES(LANES), .STAGES(STAGES)) u_pipe (
        .clk(clk), .rst_n(rst_n), .en(en),
        .in_op(iss_op), .in_addr(iss_addr), .in_bwe_n(bwe_n),
        .s1_op(s1_op), .s1_addr(s1_addr),
        .out_op(s2_op), .out_addr(s2_addr), .out_bwe_n(s2_bwe_n)
    );

    zt_array #(.AW(AW), .LANE_W(LANE_W), .LANES(LANES)) u_array (
        .clk(clk), .rst_n(rst_n), .en(en),
        .op(s2_op), .addr(s2_addr), .bwe_n(s2_bwe_n),
        .wdata(wdata), .rd_data(dq_out), .rd_live(rd_live)
    );

    assign dq_drive = rd_live && !oe_n && !sleep;
endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk
    import zt_pkg::*;
#(
    parameter int AW      = 8,
    parameter int BURST_W = 2,
    parameter int DATA_W  = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic              ld_n,
    input logic              oe_n,
    input logic              sleep,
    input logic [DATA_W-1:0] dq_out,
    input logic              dq_drive,
    input logic              rd_live,
    input op_e               iss_op,
    input logic [AW-1:0]     iss_addr,
    input op_e               s1_op,
    input logic [AW-1:0]     s1_addr,
    input op_e               s2_op
);
    assert_read_slot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (en && s2_op == OP_RD) |=> rd_live);

    assert_no_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && s2_op != OP_RD) |=> !rd_live);

    assert_burst_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ld_n) |-> (iss_addr == {s1_addr[AW-1:BURST_W],
                                       s1_addr[BURST_W-1:0] + BURST_W'(1)}));

    assert_burst_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ld_n) |-> (iss_op == s1_op));

    assert_hold_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(dq_out) && $stable(rd_live)));

    assert_oe_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_drive);

    assert_sleep_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !dq_drive);
endmodule

bind zt_sram zt_sram_chk #(.AW(AW), .BURST_W(BURST_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .ld_n(ld_n), .oe_n(oe_n),
    .sleep(sleep), .dq_out(dq_out), .dq_drive(dq_drive), .rd_live(rd_live),
    .iss_op(iss_op), .iss_addr(iss_addr), .s1_op(s1_op), .s1_addr(s1_addr),
    .s2_op(s2_op)
);

// File: tb/zt_sram_test.sv
`timescale 1ns/1ps
module zt_sram_test;
    localparam int AW = 8, LW = 9, NL = 2, DW = NL * LW;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          i_hold = 0, i_sleep = 0, i_ld_n = 0, i_rw = 1;
    logic          i_sa = 1, i_sb = 0, i_sc = 1, i_oe_n = 0;
    logic [NL-1:0] i_bwe_n = '1;
    logic [AW-1:0] i_addr = '0;
    logic [DW-1:0] i_wdata = '0;
    logic [DW-1:0] dq_out;
    logic          dq_drive;

    int    checks = 0, errors = 0;
    string tag = "R9";

    // reference model state (direction codes: 0 none, 1 read, 2 write)
    logic [DW-1:0] m_mem [1 << AW];
    int            m1_op = 0, m2_op = 0, m_dir = 0;
    logic [AW-1:0] m1_a = 0, m2_a = 0, m_base = 0;
    logic [NL-1:0] m1_bw = '1, m2_bw = '1;
    logic [DW-1:0] m_out = '0;
    logic          m_drv = 0;

    zt_sram uut (
        .clk(clk), .rst_n(rst_n), .clk_hold(i_hold), .sleep(i_sleep),
        .ld_n(i_ld_n), .rd_wr_n(i_rw), .sel_a_n(i_sa), .sel_b_n(i_sb),
        .sel_c(i_sc), .bwe_n(i_bwe_n), .addr(i_addr), .wdata(i_wdata),
        .oe_n(i_oe_n), .dq_out(dq_out), .dq_drive(dq_drive)
    );

    always #4 clk = ~clk;

    task automatic chk_bit(input string t, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: dq_drive got %0b expected %0b at %0t", t, got, exp, $time);
        end
    endtask

    task automatic chk_word(input string t, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: dq_out got %h expected %h at %0t", t, got, exp, $time);
        end
    endtask

    task automatic model_edge();
        if (!i_hold && !i_sleep) begin
            if (m2_op == 2)
                for (int l = 0; l < NL; l++)
                    if (!m2_bw[l]) m_mem[m2_a][l*LW +: LW] = i_wdata[l*LW +: LW];
            m_drv = (m2_op == 1);
            if (m2_op == 1) m_out = m_mem[m2_a];
            m2_op = m1_op; m2_a = m1_a; m2_bw = m1_bw;
            if (!i_ld_n) begin
                m_base = i_addr;
                if (!i_sa && !i_sb && i_sc) m_dir = i_rw ? 1 : 2;
                else                        m_dir = 0;
            end else begin
                m_base = {m_base[AW-1:2], m_base[1:0] + 2'd1};
            end
            m1_op = m_dir; m1_a = m_base; m1_bw = i_bwe_n;
        end
    endtask

    task automatic compare();
        logic exp_drv;
        exp_drv = m_drv && !i_oe_n && !i_sleep;
        chk_bit(tag, dq_drive, exp_drv);
        if (exp_drv) chk_word(tag, dq_out, m_out);
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic issue(input logic ld, input logic rw, input logic [AW-1:0] a,
                         input logic [NL-1:0] bw);
        i_ld_n = ld; i_rw = rw; i_addr = a; i_bwe_n = bw;
        i_wdata = DW'($urandom);
        tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_bit("R9 reset", dq_drive, 1'b0);
        rst_n = 1'b1;
        i_sa = 0;
        // R9: advances straight after reset issue nothing
        tag = "R9";
        for (int k = 0; k < 4; k++) issue(1, 1, 8'h33, 2'b00);

        // R2/R4: fill every word with write bursts that wrap in groups of four
        tag = "R2 fill";
        for (int b = 0; b < 64; b++) begin
            issue(0, 0, AW'(4 * b + (b % 4)), 2'b00);
            for (int k = 0; k < 3; k++) issue(1, 1, 8'hFF, 2'b00);
        end

        // R4: read burst from 0x0A wraps 0A,0B,08,09; rd_wr_n toggled and ignored
        tag = "R4";
        issue(0, 1, 8'h0A, 2'b11);
        for (int k = 0; k < 3; k++) issue(1, k[0], 8'h77, 2'b00);
        issue(1, 0, 8'h00, 2'b00);
        issue(1, 0, 8'h00, 2'b00);

        // R1/R3: back-to-back alternating reads and writes at one address
        tag = "R3";
        for (int k = 0; k < 8; k++) issue(0, k[0], 8'h40, 2'b00);
        tag = "R1";
        issue(0, 1, 8'h41, 2'b11);
        issue(0, 1, 8'h40, 2'b11);
        issue(0, 1, 8'h42, 2'b11);

        // R2: only lane 0 written (bwe_n=2'b10), then only lane 1 (2'b01)
        tag = "R2";
        issue(0, 0, 8'h50, 2'b10);
        issue(0, 0, 8'h51, 2'b01);
        issue(0, 1, 8'h50, 2'b11);
        issue(0, 1, 8'h51, 2'b11);
        issue(0, 1, 8'h50, 2'b11);
        issue(0, 1, 8'h51, 2'b11);

        // R5: deselected loads, then advances with all selects active
        tag = "R5";
        i_sa = 1; issue(0, 1, 8'h10, 2'b11); i_sa = 0;
        issue(1, 1, 8'h00, 2'b11);
        issue(1, 1, 8'h00, 2'b11);
        i_sc = 0; issue(0, 0, 8'h10, 2'b00); i_sc = 1;
        issue(1, 0, 8'h00, 2'b00);
        i_sb = 1; issue(0, 1, 8'h11, 2'b11);
        issue(1, 1, 8'h00, 2'b11);
        i_sb = 0;
        // selects dropped during advance: burst keeps going
        issue(0, 1, 8'h20, 2'b11);
        i_sa = 1; i_sc = 0;
        issue(1, 1, 8'h00, 2'b11);
        issue(1, 1, 8'h00, 2'b11);
        i_sa = 0; i_sc = 1;
        issue(1, 1, 8'h00, 2'b11);

        // R6: clock hold in the middle of a write/read mix
        tag = "R6";
        issue(0, 0, 8'h60, 2'b00);
        issue(0, 1, 8'h61, 2'b11);
        i_hold = 1;
        for (int k = 0; k < 3; k++) issue(0, 0, 8'h61, 2'b00);
        i_hold = 0;
        issue(0, 1, 8'h60, 2'b11);
        issue(0, 1, 8'h61, 2'b11);
        issue(0, 1, 8'h60, 2'b11);

        // R7: output enable removes drive between edges
        tag = "R7";
        issue(0, 1, 8'h61, 2'b11);
        issue(0, 1, 8'h62, 2'b11);
        i_oe_n = 1; #1;
        chk_bit("R7 async off", dq_drive, 1'b0);
        i_oe_n = 0; #1;
        chk_bit("R7 async on", dq_drive, 1'b1);
        i_oe_n = 1;
        issue(0, 1, 8'h63, 2'b11);
        i_oe_n = 0;
        issue(0, 1, 8'h63, 2'b11);

        // R8: sleep with write requests presented, then read back
        tag = "R8";
        issue(0, 1, 8'h70, 2'b11);
        i_sleep = 1;
        for (int k = 0; k < 4; k++) issue(0, 0, 8'h70, 2'b00);
        i_sleep = 0;
        issue(0, 1, 8'h70, 2'b11);
        issue(0, 1, 8'h70, 2'b11);
        issue(0, 1, 8'h70, 2'b11);

        // R3: random mix of loads, advances, stalls, sleep and output enable
        tag = "R3 random";
        for (int k = 0; k < 3000; k++) begin
            i_hold  = ($urandom % 10) == 0;
            i_sleep = ($urandom % 40) == 0;
            i_oe_n  = ($urandom % 12) == 0;
            i_sa    = ($urandom % 10) == 0;
            i_sc    = ($urandom % 10) != 0;
            issue(($urandom % 3) == 0, $urandom % 2, AW'($urandom), NL'($urandom));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule